// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address by reading up to four levels of translation tables from memory. A request carries the virtual address, the kind of access (read, write or instruction fetch) and whether the requester runs in user or supervisor mode. The walker first checks that the address is canonical. It then reads one 64-bit entry per level over a simple request/response memory port. It keeps the write, user and no-execute permissions gathered along the way, and it stops at the leaf entry.

A leaf is either a 4 KiB page at the last level or a 2 MiB page flagged by the page-size bit at the third level. The result is a one-cycle completion pulse that carries one of three outcomes: the physical address, a general-protection indication for a non-canonical address, or a page-fault indication. A page fault comes with a five-bit error code and the faulting virtual address. The walker holds no translations, writes nothing back to memory and serves one request at a time.

Top module: `ptw_walker`

## Requirements
- R1: A request whose bits 63:47 are not all equal completes with `done_gp`=1, `done_pf`=0, `done_err`=0 and `done_fault_va` equal to the request address, without issuing any memory read.
- R2: The entry read at each level sits at the table base plus 8 times that level's index. The index is taken from bits 47:39 first, then 38:30, then 29:21, then 20:12. The first base is `root_base` with its low 12 bits cleared, and every later base is entry bits PA_W-1:12 followed by 12 zero bits.
- R3: At most one read is in flight. `mem_rd_valid` stays high with `mem_rd_addr` unchanged until `mem_rd_ready` is seen, and the next read is issued only after `mem_rsp_valid` has returned the previous entry.
- R4: An entry with bit 0 clear ends the walk with a page fault whose error bit 0 is 0 and whose bit 3 is 0.
- R5: A present entry is reserved-faulted (error bits 0 and 3 both 1) in any of these cases: any of its bits 51:PA_W is set; it is at the first or second level with bit 7 set; or it is a third-level entry with bit 7 set and any of bits 20:13 set. A reserved fault takes priority over permission checks.
- R6: A present, non-reserved third-level entry with bit 7 set is a 2 MiB leaf after three reads. Its physical address is entry bits PA_W-1:21 followed by virtual address bits 20:0.
- R7: A fourth-level entry is a 4 KiB leaf after four reads. Its physical address is entry bits PA_W-1:12 followed by virtual address bits 11:0. Bit 7 at this level is not a page-size bit.
- R8: At a leaf, the walk page-faults with error bit 0 set in three cases: a user access (`req_user`=1) and bit 2 is clear in any visited entry; a write in either mode and bit 1 is clear in any visited entry; or a fetch and bit 63 is set in any visited entry. Otherwise it succeeds.
- R9: `req_kind` encodes 0 read, 1 write, 2 fetch, and 3 behaves as read. In every page-fault error code, bit 1 is 1 exactly for a write, bit 2 is 1 exactly for a user access and bit 4 is 1 exactly for a fetch. `done_fault_va` holds the request address.
- R10: `done_valid` is high for exactly one cycle per accepted request, with at most one of `done_gp` and `done_pf` set. A success reports both as 0 with `done_err`=0. `req_ready` is high only while no walk is in progress, and it is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for a user-mode access |
| root_base | input | PA_W | Physical base of the top table, sampled on accept |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Returned 64-bit entry |
| done_valid | output | 1 | One-cycle completion pulse |
| done_gp | output | 1 | Non-canonical address |
| done_pf | output | 1 | Page fault |
| done_err | output | 5 | Page-fault error code |
| done_paddr | output | PA_W | Translated physical address |
| done_fault_va | output | 64 | Faulting virtual address |

## Verification
The assertions assume three things about the memory side: each accepted read gets exactly one response, that response arrives only while the walker is waiting for it, and `req_valid` is raised only when the walker is idle. The bench meets these by acting as the memory itself in one sequential task. That task accepts each read after a varying stall, returns the entry after a latency of one or two cycles, and starts a new request only after the previous completion pulse. Read counts, error-code bits and pulse width are checked against the access kind and mode captured when the request was accepted.

// File: rtl/ptw_pkg.sv
// Shared constants and types for the page table walker.
// Assumes the four-level, 512-entry, 64-bit-entry table layout.
package ptw_pkg;
    localparam int VA_FULL   = 64;
    localparam int ENTRY_W   = 64;
    localparam int IDX_W     = 9;
    localparam int OFF_W     = 12;
    localparam int LEVELS    = 4;
    localparam int MAX_PA_W  = 52;
    localparam int ENT_SHIFT = $clog2(ENTRY_W / 8);
    localparam int ERR_W     = 5;

    // entry bit positions
    localparam int PTE_P  = 0;
    localparam int PTE_W  = 1;
    localparam int PTE_U  = 2;
    localparam int PTE_PS = 7;
    localparam int PTE_NX = 63;

    // error code bit positions
    localparam int EB_PROT  = 0;
    localparam int EB_WRITE = 1;
    localparam int EB_USER  = 2;
    localparam int EB_RSVD  = 3;
    localparam int EB_FETCH = 4;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_state_e;

    typedef struct packed {
        logic wr;
        logic usr;
        logic nx;
    } perm_t;
endpackage

// File: rtl/ptw_canon.sv
// Canonical-address check: the bits above the implemented virtual
// width must all copy the top implemented bit.
// Assumes VA_IMPL < VA_W.
module ptw_canon #(
    parameter int VA_W    = 64,
    parameter int VA_IMPL = 48
) (
    input  logic [VA_W-1:0] va,
    output logic            canonical
);
    localparam int HI_W = VA_W - VA_IMPL + 1;

    logic [HI_W-1:0] hi_bits;

    // gather the sign bit and all bits above it
    always_comb begin
        hi_bits   = va[VA_W-1:VA_IMPL-1];
        canonical = (&hi_bits) | ~(|hi_bits);
    end
endmodule

// File: rtl/ptw_addr_gen.sv
// Entry address generator: picks the index field for the current level
// and adds it, scaled by the entry size, to the table base.
// Assumes level 0 is the top table and uses the most significant index.
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  logic [LEVELS*IDX_W-1:0]    va_idx,
    input  logic [$clog2(LEVELS)-1:0]  level,
    input  logic [PA_W-OFF_W-1:0]      base_pfn,
    output logic [PA_W-1:0]            ent_addr
);
    localparam int IDXS_W = LEVELS * IDX_W;

    logic [IDX_W-1:0] idx_by_lvl [LEVELS];
    logic [IDX_W-1:0] idx_sel;

    // one index slice per level, top level from the highest bits
    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx_by_lvl[g] = va_idx[IDXS_W-1-g*IDX_W -: IDX_W];
    end

    // select this level's index and form the byte address
    always_comb begin
        idx_sel  = idx_by_lvl[level];
        ent_addr = {base_pfn, {OFF_W{1'b0}}}
                 + PA_W'({idx_sel, {ENT_SHIFT{1'b0}}});
    end
endmodule

// File: rtl/ptw_entry_eval.sv
// Entry evaluator: decodes one fetched entry at a given level, folds its
// permissions into the running set and judges present, reserved, leaf
// and permission outcomes. Also forms the leaf physical address.
// Assumes the third level may hold 2 MiB leaves and the last level 4 KiB.
module ptw_entry_eval
    import ptw_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  logic [ENTRY_W-1:0]          entry,
    input  logic [$clog2(LEVELS)-1:0]   level,
    input  perm_t                       perm_in,
    input  logic [1:0]                  kind,
    input  logic                        user,
    input  logic [OFF_W+IDX_W-1:0]      va_off,
    output logic                        not_present,
    output logic                        rsvd,
    output logic                        leaf,
    output logic                        perm_fault,
    output perm_t                       perm_out,
    output logic [PA_W-OFF_W-1:0]       next_pfn,
    output logic [PA_W-1:0]             leaf_paddr
);
    localparam int LVL_W  = $clog2(LEVELS);
    localparam int BIG_SH = OFF_W + IDX_W;
    localparam logic [LVL_W-1:0] LEAF_LVL = LVL_W'(LEVELS - 1);
    localparam logic [LVL_W-1:0] BIG_LVL  = LVL_W'(LEVELS - 2);

    logic hi_rsvd;
    logic ps;
    logic unused_entry;

    // bits above the physical width are reserved only when PA_W is narrow
    if (PA_W < MAX_PA_W) begin : g_rsvd_hi
        assign hi_rsvd = |entry[MAX_PA_W-1:PA_W];
    end else begin : g_no_rsvd_hi
        assign hi_rsvd = 1'b0;
    end

    assign unused_entry = ^entry;

    // classify the entry and accumulate permissions
    always_comb begin
        ps          = entry[PTE_PS];
        not_present = ~entry[PTE_P];
        rsvd        = hi_rsvd
                    | (ps && (level < BIG_LVL))
                    | (ps && (level == BIG_LVL) && (|entry[BIG_SH-1:OFF_W+1]));
        leaf        = (level == LEAF_LVL) | ((level == BIG_LVL) & ps);
        perm_out.wr  = perm_in.wr  & entry[PTE_W];
        perm_out.usr = perm_in.usr & entry[PTE_U];
        perm_out.nx  = perm_in.nx  | entry[PTE_NX];
        perm_fault  = (user & ~perm_out.usr)
                    | ((kind == ACC_WRITE) & ~perm_out.wr)
                    | ((kind == ACC_FETCH) & perm_out.nx);
        next_pfn    = entry[PA_W-1:OFF_W];
    end

    // leaf address: large page keeps 21 offset bits, small keeps 12
    always_comb begin
        if (level == LEAF_LVL)
            leaf_paddr = {entry[PA_W-1:OFF_W], va_off[OFF_W-1:0]};
        else
            leaf_paddr = {entry[PA_W-1:BIG_SH], va_off[BIG_SH-1:0]};
    end
endmodule

// File: rtl/ptw_walker.sv
// Page table walker top: accepts one translation request, checks the
// address is canonical, then reads one entry per level until a leaf or
// a fault, and reports the outcome with a one-cycle pulse.
// Assumes each accepted memory read gets exactly one response while the
// walker waits, and that write protection is always in force.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int PA_W    = 52,
    parameter int VA_IMPL = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_FULL-1:0]  req_vaddr,
    input  logic [1:0]          req_kind,
    input  logic                req_user,
    input  logic [PA_W-1:0]     root_base,
    output logic                mem_rd_valid,
    input  logic                mem_rd_ready,
    output logic [PA_W-1:0]     mem_rd_addr,
    input  logic                mem_rsp_valid,
    input  logic [ENTRY_W-1:0]  mem_rsp_data,
    output logic                done_valid,
    output logic                done_gp,
    output logic                done_pf,
    output logic [ERR_W-1:0]    done_err,
    output logic [PA_W-1:0]     done_paddr,
    output logic [VA_FULL-1:0]  done_fault_va
);
    localparam int LVL_W  = $clog2(LEVELS);
    localparam int PFN_W  = PA_W - OFF_W;
    localparam int IDXS_W = LEVELS * IDX_W;
    localparam int BIG_SH = OFF_W + IDX_W;
    localparam perm_t PERM_INIT = '{wr: 1'b1, usr: 1'b1, nx: 1'b0};

    walk_state_e         state;
    logic [LVL_W-1:0]    lvl;
    logic [VA_FULL-1:0]  va_q;
    logic [1:0]          kind_q;
    logic                user_q;
    logic [PFN_W-1:0]    tbl_pfn;
    perm_t               perm_q;

    logic                canon_ok;
    logic                not_present;
    logic                rsvd;
    logic                leaf;
    logic                perm_fault;
    perm_t               perm_next;
    logic [PFN_W-1:0]    next_pfn;
    logic [PA_W-1:0]     leaf_pa;
    logic                fault_now;
    logic [ERR_W-1:0]    err_now;
    logic                unused_root;

    assign unused_root = ^root_base[OFF_W-1:0];

    ptw_canon #(
        .VA_W    (VA_FULL),
        .VA_IMPL (VA_IMPL)
    ) u_canon (
        .va        (req_vaddr),
        .canonical (canon_ok)
    );

    ptw_addr_gen #(
        .PA_W (PA_W)
    ) u_addr (
        .va_idx   (va_q[OFF_W+IDXS_W-1:OFF_W]),
        .level    (lvl),
        .base_pfn (tbl_pfn),
        .ent_addr (mem_rd_addr)
    );

    ptw_entry_eval #(
        .PA_W (PA_W)
    ) u_eval (
        .entry       (mem_rsp_data),
        .level       (lvl),
        .perm_in     (perm_q),
        .kind        (kind_q),
        .user        (user_q),
        .va_off      (va_q[BIG_SH-1:0]),
        .not_present (not_present),
        .rsvd        (rsvd),
        .leaf        (leaf),
        .perm_fault  (perm_fault),
        .perm_out    (perm_next),
        .next_pfn    (next_pfn),
        .leaf_paddr  (leaf_pa)
    );

    // handshake outputs decoded from the walk state
    always_comb begin
        req_ready    = (state == ST_IDLE);
        mem_rd_valid = (state == ST_ISSUE);
        done_valid   = (state == ST_DONE);
    end

    // fault decision and error code for the entry now returning
    always_comb begin
        fault_now         = not_present | rsvd | (leaf & perm_fault);
        err_now           = '0;
        err_now[EB_PROT]  = ~not_present;
        err_now[EB_WRITE] = (kind_q == ACC_WRITE);
        err_now[EB_USER]  = user_q;
        err_now[EB_RSVD]  = ~not_present & rsvd;
        err_now[EB_FETCH] = (kind_q == ACC_FETCH);
    end

    // walk sequencer and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            lvl           <= '0;
            va_q          <= '0;
            kind_q        <= '0;
            user_q        <= 1'b0;
            tbl_pfn       <= '0;
            perm_q        <= PERM_INIT;
            done_gp       <= 1'b0;
            done_pf       <= 1'b0;
            done_err      <= '0;
            done_paddr    <= '0;
            done_fault_va <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        kind_q  <= req_kind;
                        user_q  <= req_user;
                        tbl_pfn <= root_base[PA_W-1:OFF_W];
                        lvl     <= '0;
                        perm_q  <= PERM_INIT;
                        if (canon_ok) begin
                            state <= ST_ISSUE;
                        end else begin
                            done_gp       <= 1'b1;
                            done_pf       <= 1'b0;
                            done_err      <= '0;
                            done_paddr    <= '0;
                            done_fault_va <= req_vaddr;
                            state         <= ST_DONE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (mem_rd_ready)
                        state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        perm_q <= perm_next;
                        if (fault_now) begin
                            done_gp       <= 1'b0;
                            done_pf       <= 1'b1;
                            done_err      <= err_now;
                            done_paddr    <= '0;
                            done_fault_va <= va_q;
                            state         <= ST_DONE;
                        end else if (leaf) begin
                            done_gp       <= 1'b0;
                            done_pf       <= 1'b0;
                            done_err      <= '0;
                            done_paddr    <= leaf_pa;
                            done_fault_va <= '0;
                            state         <= ST_DONE;
                        end else begin
                            tbl_pfn <= next_pfn;
                            lvl     <= lvl + 1'b1;
                            state   <= ST_ISSUE;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/ptw_walker_chk.sv
// Checker for the page table walker: counts reads per request and
// relates handshakes, completion pulses and error codes over time.
// Assumes req_valid rises only while req_ready is high.
module ptw_walker_chk #(
    parameter int PA_W = 52
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [1:0]      req_kind,
    input logic            req_user,
    input logic            mem_rd_valid,
    input logic            mem_rd_ready,
    input logic [PA_W-1:0] mem_rd_addr,
    input logic            done_valid,
    input logic            done_gp,
    input logic            done_pf,
    input logic [4:0]      done_err
);
    logic [2:0] reads_cnt;
    logic [1:0] kind_c;
    logic       user_c;

    // count accepted reads since the last accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reads_cnt <= '0;
            kind_c    <= '0;
            user_c    <= 1'b0;
        end else if (req_valid && req_ready) begin
            reads_cnt <= '0;
            kind_c    <= req_kind;
            user_c    <= req_user;
        end else if (mem_rd_valid && mem_rd_ready) begin
            reads_cnt <= reads_cnt + 3'd1;
        end
    end

    a_r3_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    a_r3_read_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready && !done_valid);

    a_r1_gp_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_gp |-> reads_cnt == 3'd0 && done_err == 5'd0);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !(done_gp && done_pf));

    a_r9_err_kind: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_pf |-> (done_err[1] == (kind_c == 2'd1))
                               && (done_err[4] == (kind_c == 2'd2))
                               && (done_err[2] == user_c));

    a_r6_r7_leaf_reads: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && !done_pf && !done_gp |-> reads_cnt == 3'd3 || reads_cnt == 3'd4);

    a_r5_rsvd_is_present: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_err[3] |-> done_err[0]);
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_kind     (req_kind),
    .req_user     (req_user),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .done_valid   (done_valid),
    .done_gp      (done_gp),
    .done_pf      (done_pf),
    .done_err     (done_err)
);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    localparam int CLK_PERIOD = 10;
    localparam int PA_W = 40;

    localparam logic [39:0] ROOT  = 40'h1000;
    localparam logic [39:0] PDPT  = 40'h2000;
    localparam logic [39:0] PDIR  = 40'h3000;
    localparam logic [39:0] PTAB  = 40'h4000;
    localparam logic [39:0] FRAME = 40'hABCDE000;
    localparam logic [39:0] BIGF  = 40'h740000000;
    localparam logic [63:0] VA_A  = {16'h0, 9'd1, 9'd2, 9'd3, 9'd4, 12'h567};
    localparam logic [63:0] VA_H  = 64'hFFFF_FF80_0000_1000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [63:0]     req_vaddr = '0;
    logic [1:0]      req_kind = '0;
    logic            req_user = 1'b0;
    logic [PA_W-1:0] root_base = ROOT | 40'hABC;
    logic            mem_rd_valid;
    logic            mem_rd_ready = 1'b0;
    logic [PA_W-1:0] mem_rd_addr;
    logic            mem_rsp_valid = 1'b0;
    logic [63:0]     mem_rsp_data = '0;
    logic            done_valid;
    logic            done_gp;
    logic            done_pf;
    logic [4:0]      done_err;
    logic [PA_W-1:0] done_paddr;
    logic [63:0]     done_fault_va;

    int vecs = 0;
    int fails = 0;
    int walk_no = 0;

    logic [63:0] pmem [logic [39:0]];
    logic [39:0] exp_addr [4];
    logic        e_gp, e_pf;
    logic [4:0]  e_err;
    logic [39:0] e_pa;
    int          e_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker #(.PA_W(PA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_user(req_user), .root_base(root_base),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_gp(done_gp), .done_pf(done_pf),
        .done_err(done_err), .done_paddr(done_paddr), .done_fault_va(done_fault_va)
    );

    function automatic logic [63:0] rd(input logic [39:0] a);
        if (pmem.exists(a)) return pmem[a];
        return 64'h0;
    endfunction

    function automatic logic [63:0] ent(input logic [39:0] base, input bit w, input bit u, input bit nx);
        return {nx, 23'h0, base} | {61'h0, u, w, 1'b1};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // reference translation computed from the requirements
    task automatic ref_walk(input logic [63:0] va, input logic [1:0] kind, input bit user);
        logic [39:0] base;
        logic [63:0] e;
        bit w, u, nx, rs, lf, wr_k, fe_k;
        wr_k = (kind == 2'd1);
        fe_k = (kind == 2'd2);
        e_gp = 0; e_pf = 0; e_err = 0; e_pa = 0; e_n = 0;
        if (!((&va[63:47]) || !(|va[63:47]))) begin
            e_gp = 1;
            return;
        end
        base = {root_base[39:12], 12'h0};
        w = 1; u = 1; nx = 0;
        for (int lv = 0; lv < 4; lv++) begin
            exp_addr[lv] = base + {va[47-9*lv -: 9], 3'b000};
            e = rd(exp_addr[lv]);
            e_n++;
            if (!e[0]) begin
                e_pf = 1; e_err = {fe_k, 1'b0, user, wr_k, 1'b0};
                return;
            end
            rs = (|e[51:40]) || (e[7] && lv < 2) || (e[7] && lv == 2 && (|e[20:13]));
            if (rs) begin
                e_pf = 1; e_err = {fe_k, 1'b1, user, wr_k, 1'b1};
                return;
            end
            w = w & e[1]; u = u & e[2]; nx = nx | e[63];
            lf = (lv == 3) || (lv == 2 && e[7]);
            if (lf) begin
                if ((user && !u) || (wr_k && !w) || (fe_k && nx)) begin
                    e_pf = 1; e_err = {fe_k, 1'b0, user, wr_k, 1'b1};
                end else if (lv == 3) begin
                    e_pa = {e[39:12], va[11:0]};
                end else begin
                    e_pa = {e[39:21], va[20:0]};
                end
                return;
            end
            base = {e[39:12], 12'h0};
        end
    endtask

    // standard path for VA_A with per-level flags
    task automatic build(input logic [63:0] e0, input logic [63:0] e1,
                         input logic [63:0] e2, input logic [63:0] e3);
        pmem.delete();
        pmem[ROOT + 40'd8]  = e0;
        pmem[PDPT + 40'd16] = e1;
        pmem[PDIR + 40'd24] = e2;
        pmem[PTAB + 40'd32] = e3;
    endtask

    // drive one request, act as memory, compare the outcome
    task automatic run_walk(input logic [63:0] va, input logic [1:0] kind,
                            input bit user, input string tag);
        logic [39:0] a_q;
        int rsp_wait, stall_left, stall, lat, n_rd, cyc;
        bit done_seen;
        ref_walk(va, kind, user);
        stall = walk_no % 3;
        lat = 1 + (walk_no % 2);
        walk_no++;
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_kind = kind; req_user = user;
        @(negedge clk);
        req_valid = 0;
        rsp_wait = 0; stall_left = stall; n_rd = 0; cyc = 0; a_q = '0;
        done_seen = 0;
        while (!done_seen) begin
            mem_rsp_valid = 0;
            mem_rd_ready = 0;
            if (done_valid) begin
                done_seen = 1;
            end else if (cyc > 400) begin
                check(0, tag, "walk timeout", 64'(cyc), 64'd0);
                return;
            end else begin
                if (rsp_wait > 0) begin
                    rsp_wait--;
                    if (rsp_wait == 0) begin
                        mem_rsp_valid = 1;
                        mem_rsp_data = rd(a_q);
                    end
                end else if (mem_rd_valid) begin
                    if (stall_left > 0) stall_left--;
                    else begin
                        mem_rd_ready = 1;
                        a_q = mem_rd_addr;
                        if (n_rd < 4)
                            check(a_q == exp_addr[n_rd], "R2", "entry address",
                                  64'(a_q), 64'(exp_addr[n_rd]));
                        n_rd++;
                        rsp_wait = lat;
                        stall_left = stall;
                    end
                end
                @(negedge clk);
                cyc++;
            end
        end
        check({done_gp, done_pf, done_err} == {e_gp, e_pf, e_err}, tag, "gp/pf/err",
              64'({done_gp, done_pf, done_err}), 64'({e_gp, e_pf, e_err}));
        if (e_gp || e_pf)
            check(done_fault_va == va, tag, "fault va", done_fault_va, va);
        else
            check(done_paddr == e_pa, tag, "paddr", 64'(done_paddr), 64'(e_pa));
        check(n_rd == e_n, tag, "read count", 64'(n_rd), 64'(e_n));
        @(negedge clk);
        check(!done_valid && req_ready, "R10", "pulse one cycle",
              64'({done_valid, req_ready}), 64'b01);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog: actual expired expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check(req_ready && !done_valid && !mem_rd_valid, "R10", "reset state",
              64'({req_ready, done_valid, mem_rd_valid}), 64'b100);
        rst_n = 1;

        // R8/R9/R7 permission sweep over 4 KiB path
        for (int m = 0; m < 64; m++) begin
            build(ent(PDPT, m[0], m[1], 0), ent(PDIR, 1, 1, m[4]),
                  ent(PTAB, 1, 1, 0), ent(FRAME, m[2], m[3], m[5]));
            for (int k = 0; k < 3; k++)
                for (int us = 0; us < 2; us++)
                    run_walk(VA_A, 2'(k), us[0], "R8/R9/R7");
        end

        // R9 kind 3 behaves as read
        build(ent(PDPT, 0, 1, 1), ent(PDIR, 1, 1, 0), ent(PTAB, 1, 1, 0), ent(FRAME, 0, 0, 0));
        run_walk(VA_A, 2'd3, 1'b0, "R9");
        run_walk(VA_A, 2'd3, 1'b1, "R9");

        // R7 bit 7 at last level is not a size bit
        build(ent(PDPT, 1, 1, 0), ent(PDIR, 1, 1, 0), ent(PTAB, 1, 1, 0),
              ent(FRAME, 1, 1, 0) | 64'h80);
        run_walk(VA_A, 2'd0, 1'b0, "R7");

        // R4 not present at each level
        for (int lv = 0; lv < 4; lv++)
            for (int k = 0; k < 3; k++)
                for (int us = 0; us < 2; us++) begin
                    logic [63:0] q [4];
                    q[0] = ent(PDPT, 1, 1, 0); q[1] = ent(PDIR, 1, 1, 0);
                    q[2] = ent(PTAB, 1, 1, 0); q[3] = ent(FRAME, 1, 1, 0);
                    q[lv] = q[lv] & ~64'h1;
                    build(q[0], q[1], q[2], q[3]);
                    run_walk(VA_A, 2'(k), us[0], "R4");
                end

        // R5 reserved cases
        for (int lv = 0; lv < 4; lv++)
            for (int k = 0; k < 2; k++) begin
                logic [63:0] q [4];
                q[0] = ent(PDPT, 1, 1, 0); q[1] = ent(PDIR, 1, 1, 0);
                q[2] = ent(PTAB, 1, 1, 0); q[3] = ent(FRAME, 0, 0, 1);
                q[lv] = q[lv] | (64'h1 << (40 + 3 * lv));
                build(q[0], q[1], q[2], q[3]);
                run_walk(VA_A, 2'(k), k[0], "R5");
            end
        build(ent(PDPT, 1, 1, 0) | 64'h80, ent(PDIR, 1, 1, 0), ent(PTAB, 1, 1, 0), ent(FRAME, 1, 1, 0));
        run_walk(VA_A, 2'd0, 1'b0, "R5");
        build(ent(PDPT, 1, 1, 0), ent(PDIR, 1, 1, 0) | 64'h80, ent(PTAB, 1, 1, 0), ent(FRAME, 1, 1, 0));
        run_walk(VA_A, 2'd2, 1'b1, "R5");
        build(ent(PDPT, 1, 1, 0), ent(PDIR, 1, 1, 0), ent(BIGF | 40'h2000, 0, 0, 0) | 64'h80, 64'h0);
        run_walk(VA_A, 2'd1, 1'b1, "R5");
        build(ent(PDPT, 1, 1, 0), ent(PDIR, 1, 1, 0), ent(BIGF | 40'h100000, 1, 1, 0) | 64'h80, 64'h0);
        run_walk(VA_A, 2'd0, 1'b0, "R5");
        build(ent(PDPT, 1, 1, 0), ent(PDIR, 1, 1, 0), ent(BIGF | 40'h1000, 1, 1, 0) | 64'h80, 64'h0);
        run_walk(VA_A, 2'd0, 1'b0, "R6");

        // R6 2 MiB leaves with permission sweep
        for (int f = 0; f < 8; f++)
            for (int k = 0; k < 3; k++)
                for (int us = 0; us < 2; us++) begin
                    build(ent(PDPT, 1, 1, 0), ent(PDIR, 1, 1, 0),
                          ent(BIGF, f[0], f[1], f[2]) | 64'h80, 64'h0);
                    run_walk(VA_A, 2'(k), us[0], "R6/R8");
                end

        // R2 upper-half canonical address walks through index 511
        pmem.delete();
        pmem[ROOT + 40'hFF8] = ent(PDPT, 1, 1, 0);
        pmem[PDPT]           = ent(PDIR, 1, 1, 0);
        pmem[PDIR]           = ent(PTAB, 1, 1, 0);
        pmem[PTAB + 40'd8]   = ent(FRAME, 1, 1, 0);
        for (int k = 0; k < 3; k++)
            run_walk(VA_H, 2'(k), 1'b1, "R2");

        // R1 non-canonical addresses never walk
        for (int b = 48; b < 64; b++) begin
            run_walk(VA_A ^ (64'h1 << b), 2'd1, 1'b0, "R1");
            run_walk(VA_H ^ (64'h1 << b), 2'd2, 1'b1, "R1");
        end
        run_walk(VA_A | (64'h1 << 47), 2'd0, 1'b0, "R1");
        run_walk(VA_H & ~(64'h1 << 47), 2'd0, 1'b1, "R1");
        // R3 is exercised by the stall/latency pattern of every walk above

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule